// File: doc/BRIEF.md
# Dual-Input Up/Down Counter with Cascade Outputs

This block is a binary counter that wraps modulo 2^WIDTH. It has no direction pin. Instead it has two count inputs. A rising edge on the up input adds one to the value, and a rising edge on the down input subtracts one. A high clear input zeroes the value and wins over everything else. A low load input copies a data word into the counter and keeps doing so for as long as it stays low.

Everything runs on one free-running system clock. The two count inputs are treated as asynchronous. Each passes through a synchronizer, and its rising edge is found by comparing the current synchronized sample with the one before it. The clear and load inputs are not synchronized: they take effect at the next clock edge.

Two active-low outputs let stages be chained with no extra gating. The carry output is low while the value is at its maximum and the synchronized up input is low. The borrow output is low while the value is zero and the synchronized down input is low. Each one therefore repeats the count pulse only when the stage is about to wrap. Wiring carry to the next stage's up input and borrow to its down input makes a wider counter.

Top module: `updn_dual_counter`

## Requirements
- R1: The count wraps. An increment from 2^WIDTH-1 gives 0, and a decrement from 0 gives 2^WIDTH-1.
- R2: A rising edge on `cnt_up_i` while `cnt_dn_i` stays high adds one to `q_o`. The change shows after the third clock edge that follows the input rising, and not before.
- R3: A rising edge on `cnt_dn_i` while `cnt_up_i` stays high subtracts one from `q_o`.
- R4: A rising edge on one count input while the other count input is held low leaves `q_o` unchanged.
- R5: Rising edges on both count inputs in the same cycle leave `q_o` unchanged.
- R6: When `clear_i` is high, `q_o` becomes 0 at the next clock edge. This holds whatever `load_n_i` and the count inputs are doing.
- R7: When `clear_i` is low and `load_n_i` is low, `q_o` takes `din_i` at the next clock edge. It keeps following `din_i` while `load_n_i` stays low, and count edges have no effect during that time.
- R8: `carry_n_o` is low exactly when `q_o` is all ones, the synchronized up input is low, `clear_i` is low and `load_n_i` is high. In every other case it is high.
- R9: `borrow_n_o` is low exactly when `q_o` is zero, the synchronized down input is low, `clear_i` is low and `load_n_i` is high. In every other case it is high.
- R10: Two stages chained carry-to-up and borrow-to-down count as one counter of twice the width, including the wraps at the top value and at zero.
- R11: While `rst` is high at a clock edge, `q_o` becomes 0 and both cascade outputs are high. The synchronizers reset to the idle-high level, so releasing reset produces no count.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_up_i | input | 1 | Count-up input; counts on a rising edge, idles high |
| cnt_dn_i | input | 1 | Count-down input; counts on a rising edge, idles high |
| clear_i | input | 1 | Clear to zero, active high, highest priority |
| load_n_i | input | 1 | Preset load, active low |
| din_i | input | WIDTH | Preset data |
| q_o | output | WIDTH | Registered count value |
| carry_n_o | output | 1 | Active-low carry for cascading into the next up input |
| borrow_n_o | output | 1 | Active-low borrow for cascading into the next down input |

## Verification
A corrupted count register shows up on `q_o` at once. Because the value is a plain binary word, any wrong step also puts the cascade outputs wrong at the next terminal value. A synchronizer stuck at the wrong level or an edge detector that fires wrongly is seen within one count pulse, as a missing step, a double step or a step that should have been blocked. The terminal decode is checked in the cycles when a count input is low, because that is the only time the cascade outputs can go low. A mistake there shows up either as a mismatch on the output pin or as a wrong value in the chained pair.

// File: rtl/updn_pkg.sv
package updn_pkg;

  // Action applied to the count register at the next clock edge.
  typedef enum logic [2:0] {
    ACT_HOLD  = 3'd0,
    ACT_CLEAR = 3'd1,
    ACT_LOAD  = 3'd2,
    ACT_INC   = 3'd3,
    ACT_DEC   = 3'd4
  } count_act_e;

endpackage

// File: rtl/updn_edge_sync.sv
module updn_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic async_i,
  output logic level_o,
  output logic rise_o
);

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  // First stage samples the raw input. The chain resets to the idle-high level.
  always_ff @(posedge clk) begin
    if (rst) chain_q[0] <= 1'b1;
    else     chain_q[0] <= async_i;
  end

  genvar gi;
  generate
    for (gi = 1; gi < STAGES; gi++) begin : g_stage
      always_ff @(posedge clk) begin
        if (rst) chain_q[gi] <= 1'b1;
        else     chain_q[gi] <= chain_q[gi-1];
      end
    end
  endgenerate

  // Holds the previous synchronized sample for edge detection.
  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= chain_q[STAGES-1];
  end

  assign level_o = chain_q[STAGES-1];
  assign rise_o  = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/updn_count_core.sv
module updn_count_core
  import updn_pkg::*;
#(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  count_act_e       act_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] q_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

  logic [WIDTH-1:0] q_r;

  // Every bit changes on the same edge. The add and subtract wrap naturally at WIDTH bits.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_r <= '0;
    end else begin
      unique case (act_i)
        ACT_CLEAR: q_r <= '0;
        ACT_LOAD:  q_r <= din_i;
        ACT_INC:   q_r <= q_r + ONE;
        ACT_DEC:   q_r <= q_r - ONE;
        default:   q_r <= q_r;
      endcase
    end
  end

  assign q_o = q_r;

endmodule

// File: rtl/updn_term_decode.sv
module updn_term_decode #(
  parameter int WIDTH = 4
) (
  input  logic [WIDTH-1:0] q_i,
  input  logic             up_level_i,
  input  logic             dn_level_i,
  input  logic             clear_i,
  input  logic             load_n_i,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  logic at_top;
  logic at_zero;
  logic counting;

  assign at_top   = &q_i;
  assign at_zero  = ~|q_i;
  assign counting = ~clear_i & load_n_i;

  // Each output goes low only while its own count input is low at the terminal value.
  assign carry_n_o  = ~(at_top  & ~up_level_i & counting);
  assign borrow_n_o = ~(at_zero & ~dn_level_i & counting);

endmodule

// File: rtl/updn_dual_counter.sv
module updn_dual_counter
  import updn_pkg::*;
#(
  parameter int WIDTH       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             cnt_up_i,
  input  logic             cnt_dn_i,
  input  logic             clear_i,
  input  logic             load_n_i,
  input  logic [WIDTH-1:0] din_i,
  output logic [WIDTH-1:0] q_o,
  output logic             carry_n_o,
  output logic             borrow_n_o
);

  logic       up_level, up_rise;
  logic       dn_level, dn_rise;
  count_act_e act;

  updn_edge_sync #(.STAGES(SYNC_STAGES)) u_up_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (cnt_up_i),
    .level_o (up_level),
    .rise_o  (up_rise)
  );

  updn_edge_sync #(.STAGES(SYNC_STAGES)) u_dn_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (cnt_dn_i),
    .level_o (dn_level),
    .rise_o  (dn_rise)
  );

  // Priority: clear, then load, then a single count edge while the other input is high.
  always_comb begin
    if (clear_i)                              act = ACT_CLEAR;
    else if (!load_n_i)                       act = ACT_LOAD;
    else if (up_rise && dn_level && !dn_rise) act = ACT_INC;
    else if (dn_rise && up_level && !up_rise) act = ACT_DEC;
    else                                      act = ACT_HOLD;
  end

  updn_count_core #(.WIDTH(WIDTH)) u_core (
    .clk   (clk),
    .rst   (rst),
    .act_i (act),
    .din_i (din_i),
    .q_o   (q_o)
  );

  updn_term_decode #(.WIDTH(WIDTH)) u_decode (
    .q_i        (q_o),
    .up_level_i (up_level),
    .dn_level_i (dn_level),
    .clear_i    (clear_i),
    .load_n_i   (load_n_i),
    .carry_n_o  (carry_n_o),
    .borrow_n_o (borrow_n_o)
  );

endmodule

// File: rtl/updn_dual_counter_chk.sv
module updn_dual_counter_chk #(
  parameter int WIDTH = 4
) (
  input logic             clk,
  input logic             rst,
  input logic             clear_i,
  input logic             load_n_i,
  input logic [WIDTH-1:0] din_i,
  input logic [WIDTH-1:0] q_o,
  input logic             carry_n_o,
  input logic             borrow_n_o
);

  localparam logic [WIDTH-1:0] ONE = WIDTH'(1);
  localparam logic [WIDTH-1:0] TOP = '1;

  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> (q_o == '0)); // R6

  AST_LOAD_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && !load_n_i) |=> (q_o == $past(din_i))); // R7

  AST_SINGLE_STEP: assert property (@(posedge clk) disable iff (rst)
    (!clear_i && load_n_i) |=> (q_o == $past(q_o) || q_o == $past(q_o) + ONE || q_o == $past(q_o) - ONE)); // R1

  AST_CARRY_AT_TOP: assert property (@(posedge clk) disable iff (rst)
    !carry_n_o |-> (q_o == TOP && !clear_i && load_n_i)); // R8

  AST_BORROW_AT_ZERO: assert property (@(posedge clk) disable iff (rst)
    !borrow_n_o |-> (q_o == '0 && !clear_i && load_n_i)); // R9

  AST_CASCADE_EXCLUSIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({~carry_n_o, ~borrow_n_o})); // R10

  AST_RESET_STATE: assert property (@(posedge clk)
    $past(rst) |-> (carry_n_o && borrow_n_o)); // R11

endmodule

bind updn_dual_counter updn_dual_counter_chk #(.WIDTH(WIDTH)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .clear_i    (clear_i),
  .load_n_i   (load_n_i),
  .din_i      (din_i),
  .q_o        (q_o),
  .carry_n_o  (carry_n_o),
  .borrow_n_o (borrow_n_o)
);

// File: tb/updn_dual_counter_bench.sv
`timescale 1ns/1ps
module updn_dual_counter_bench;

  localparam int W   = 4;
  localparam int MOD = 1 << W;

  logic clk = 1'b0;
  logic rst;
  always #2 clk = ~clk;

  logic         up, dn, clr, ld_n;
  logic [W-1:0] din;
  logic [W-1:0] q;
  logic         co, bo;

  updn_dual_counter #(.WIDTH(W)) u_updn_dual_counter (
    .clk(clk), .rst(rst), .cnt_up_i(up), .cnt_dn_i(dn), .clear_i(clr),
    .load_n_i(ld_n), .din_i(din), .q_o(q), .carry_n_o(co), .borrow_n_o(bo)
  );

  // Two stages chained into one counter of twice the width.
  logic         c_up, c_dn, c_clr, c_ld_n;
  logic [2*W-1:0] c_din;
  logic [W-1:0] lo_q, hi_q;
  logic         lo_co, lo_bo, hi_co, hi_bo;

  updn_dual_counter #(.WIDTH(W)) u_casc_lo (
    .clk(clk), .rst(rst), .cnt_up_i(c_up), .cnt_dn_i(c_dn), .clear_i(c_clr),
    .load_n_i(c_ld_n), .din_i(c_din[W-1:0]), .q_o(lo_q), .carry_n_o(lo_co), .borrow_n_o(lo_bo)
  );

  updn_dual_counter #(.WIDTH(W)) u_casc_hi (
    .clk(clk), .rst(rst), .cnt_up_i(lo_co), .cnt_dn_i(lo_bo), .clear_i(c_clr),
    .load_n_i(c_ld_n), .din_i(c_din[2*W-1:W]), .q_o(hi_q), .carry_n_o(hi_co), .borrow_n_o(hi_bo)
  );

  int checks = 0;
  int errors = 0;
  int exp_q  = 0;
  int exp_c  = 0;
  bit done   = 1'b0;

  function automatic int step_up(int v, int m);
    return (v + 1) % m;
  endfunction

  function automatic int step_dn(int v, int m);
    return (v + m - 1) % m;
  endfunction

  function automatic int carry_exp(int v, bit up_low);
    return (v == MOD - 1 && up_low) ? 0 : 1;
  endfunction

  function automatic int borrow_exp(int v, bit dn_low);
    return (v == 0 && dn_low) ? 0 : 1;
  endfunction

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse_up();
    up = 1'b0;
    tick(4);
    chk("R8 carry during up pulse", int'(co), carry_exp(exp_q, 1'b1));
    up = 1'b1;
    tick(4);
    exp_q = step_up(exp_q, MOD);
    chk("R2/R1 up count", int'(q), exp_q);
  endtask

  task automatic pulse_dn();
    dn = 1'b0;
    tick(4);
    chk("R9 borrow during down pulse", int'(bo), borrow_exp(exp_q, 1'b1));
    dn = 1'b1;
    tick(4);
    exp_q = step_dn(exp_q, MOD);
    chk("R3/R1 down count", int'(q), exp_q);
  endtask

  task automatic do_load(logic [W-1:0] v);
    din  = v;
    ld_n = 1'b0;
    tick(2);
    exp_q = int'(v);
    chk("R7 load", int'(q), exp_q);
    ld_n = 1'b1;
    tick(1);
  endtask

  task automatic c_pulse(bit go_up);
    if (go_up) c_up = 1'b0; else c_dn = 1'b0;
    tick(4);
    if (go_up) c_up = 1'b1; else c_dn = 1'b1;
    tick(10);
    exp_c = go_up ? step_up(exp_c, MOD * MOD) : step_dn(exp_c, MOD * MOD);
    chk("R10 chained count", int'({hi_q, lo_q}), exp_c);
  endtask

  initial begin
    void'($urandom(32'h5EED_1234));
    rst = 1'b1; up = 1'b1; dn = 1'b1; clr = 1'b0; ld_n = 1'b1; din = '0;
    c_up = 1'b1; c_dn = 1'b1; c_clr = 1'b0; c_ld_n = 1'b1; c_din = '0;
    tick(3);
    chk("R11 reset count", int'(q), 0);
    chk("R11 reset carry", int'(co), 1);
    chk("R11 reset borrow", int'(bo), 1);
    rst = 1'b0;
    tick(4);
    chk("R11 no count on release", int'(q), 0);

    // R1: the down wrap from zero, then the up wrap back to zero
    pulse_dn();
    chk("R1 wrap down to top", int'(q), MOD - 1);
    pulse_up();
    chk("R1 wrap up to zero", int'(q), 0);

    // R2: latency of three edges after the raw input rises
    do_load(4'd6);
    up = 1'b0;
    tick(4);
    up = 1'b1;
    tick(2);
    chk("R2 no change before third edge", int'(q), 6);
    tick(1);
    chk("R2 change at third edge", int'(q), 7);
    exp_q = 7;
    tick(2);

    // R4: an up edge while down is held low has no effect; releasing down then decrements (R3)
    dn = 1'b0; tick(4);
    up = 1'b0; tick(4);
    up = 1'b1; tick(4);
    chk("R4 up blocked by low down", int'(q), exp_q);
    dn = 1'b1; tick(4);
    exp_q = step_dn(exp_q, MOD);
    chk("R3 down edge with up high", int'(q), exp_q);

    // R5: both count inputs rise in the same cycle
    up = 1'b0; dn = 1'b0; tick(4);
    up = 1'b1; dn = 1'b1; tick(4);
    chk("R5 simultaneous edges", int'(q), exp_q);

    // R7: while load is held low the value follows the data and ignores counts
    din = 4'd5; ld_n = 1'b0; tick(2);
    up = 1'b0; tick(4); up = 1'b1; tick(4);
    chk("R7 load holds over count", int'(q), 5);
    din = 4'd15; tick(1);
    chk("R7 load tracks data", int'(q), 15);
    up = 1'b0; tick(4);
    chk("R8 carry high during load", int'(co), 1);
    up = 1'b1; tick(4);
    ld_n = 1'b1; tick(1);
    exp_q = 15;

    // R6: clear wins over load and counts; borrow stays high during clear
    din = 4'd9; ld_n = 1'b0; clr = 1'b1; tick(2);
    chk("R6 clear over load", int'(q), 0);
    dn = 1'b0; tick(4);
    chk("R9 borrow high during clear", int'(bo), 1);
    dn = 1'b1; tick(4);
    chk("R6 clear over count", int'(q), 0);
    clr = 1'b0; ld_n = 1'b1; tick(1);
    exp_q = 0;

    // Constrained random sequence of operations
    for (int i = 0; i < 150; i++) begin
      int op;
      op = int'($urandom_range(0, 5));
      case (op)
        0, 1: pulse_up();
        2:    pulse_dn();
        3:    do_load(W'($urandom_range(0, MOD - 1)));
        4: begin
          clr = 1'b1; tick(2); clr = 1'b0; tick(1);
          exp_q = 0;
          chk("R6 random clear", int'(q), exp_q);
        end
        default: begin
          up = 1'b0; dn = 1'b0; tick(4);
          up = 1'b1; dn = 1'b1; tick(4);
          chk("R5 random simultaneous", int'(q), exp_q);
        end
      endcase
      chk("R8 carry idle high", int'(co), 1);
      chk("R9 borrow idle high", int'(bo), 1);
    end

    // R10: the chained pair wraps at its top value and at zero
    exp_c = 0;
    c_pulse(1'b0);
    chk("R10 chained wrap down", int'({hi_q, lo_q}), MOD * MOD - 1);
    c_pulse(1'b1);
    chk("R10 chained wrap up", int'({hi_q, lo_q}), 0);
    c_din = 8'h0F; c_ld_n = 1'b0; tick(2); c_ld_n = 1'b1; tick(1);
    exp_c = 8'h0F;
    c_pulse(1'b1);
    c_pulse(1'b0);
    c_din = 8'hFC; c_ld_n = 1'b0; tick(2); c_ld_n = 1'b1; tick(1);
    exp_c = 8'hFC;
    for (int i = 0; i < 6; i++) c_pulse(1'b1);
    for (int i = 0; i < 6; i++) c_pulse(1'b0);

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(4 * 200000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule